// File: doc/BRIEF.md
# Timed Alphabet Stepper

This block walks a seven-segment display through the letters A to Z, advancing one letter per slow tick and starting again at A after Z. A programmable divider counts fast clock cycles and raises a one-cycle tick each time it reaches its terminal value. Each tick advances a letter counter that runs from 0 to 25 and reloads 0 synchronously on the tick that finds it at 25.

A 5-bit offset input rotates the shown letter around the alphabet without touching the counter. The rotated index drives a fixed table of active-low segment patterns. The divider and the letter counter each have their own synchronous reset, and the divider has an enable. The tick is also brought out as a debug output.

With a 25 MHz clock, the default terminal value of 7,552,499 gives one letter roughly every 0.3 s. A testbench can override it with a small value.

Top module: `alpha_stepper`

## Requirements
- R1: While `tickEn` is high, `tickDbg` is high for exactly one cycle in every TICK_LIMIT+1 cycles. It is never high in two consecutive cycles.
- R2: While `tickEn` is low, `tickDbg` stays low and the divider holds its count. Counting resumes from that count when `tickEn` returns high.
- R3: `tickRst` is synchronous and active high and sets the divider count to 0. After it, `tickDbg` next rises once TICK_LIMIT enabled clock edges have passed.
- R4: The letter count rises by exactly one on a clock edge where `tickDbg` is high, and holds on every other edge.
- R5: When the count is 25 and a tick occurs, the next edge loads 0 synchronously. The shown letter returns to A (with zero offset) after Z.
- R6: `letterRst` is synchronous and active high and sets the letter count to 0. It takes priority over a tick that falls in the same cycle.
- R7: The shown index is (count + (rotIn mod 26)) mod 26. Offsets 26 to 31 act as 0 to 5.
- R8: `segOut` is active low with bit 0 = segment a through bit 6 = segment g. Indices 0 to 25 map to hex 08,03,46,21,06,0E,42,09,4F,61,0A,47,6A,2B,40,0C,18,2F,12,07,41,63,55,49,11,24, all distinct.
- R9: `tickRst` leaves the letter count unchanged, and `letterRst` leaves the divider phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| tickRst | input | 1 | Synchronous reset of the tick divider, active high |
| letterRst | input | 1 | Synchronous reset of the letter counter to A, active high |
| tickEn | input | 1 | Tick divider enable |
| rotIn | input | 5 | Letter rotation offset |
| segOut | output | 7 | Active-low segment pattern, bit 0 = a |
| tickDbg | output | 1 | One-cycle tick, for debug |

## Verification
Two events can fall in the same cycle: the clear of the letter counter and the tick that would advance it. A tick can also land on count 25, where the wrap and the clear meet. The bench follows the divider phase in its own model and raises `letterRst` exactly in a cycle where the tick is due. It then checks that the display shows A next and that the divider keeps its phase. The wrap is exercised under a large offset, where the rotated index crosses 25 at a different point from the counter's own reload, and every cycle is compared against the expected pattern.

// File: rtl/alpha_pkg.sv
package alpha_pkg;
  localparam int LETTERS = 26;
  localparam int IDX_W   = $clog2(LETTERS);
  localparam int SEG_W   = 7;

  typedef struct packed {
    logic step;   // advance by one
    logic load;   // synchronous reload of zero at the top
    logic clear;  // counter reset
  } letter_ctl_t;
endpackage

// File: rtl/alpha_ctrl.sv
module alpha_ctrl
  import alpha_pkg::*;
#(
  parameter int TICK_LIMIT = 7552499
) (
  input  logic        clk,
  input  logic        tickRst,
  input  logic        tickEn,
  input  logic        letterRst,
  input  logic        atTop,
  output letter_ctl_t ctl,
  output logic        tick
);
  localparam int DIV_W = $clog2(TICK_LIMIT + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_LIMIT);

  logic [DIV_W-1:0] divCnt;
  logic             atLimit;

  assign atLimit = (divCnt == DIV_LAST);
  assign tick    = tickEn & atLimit;

  always_ff @(posedge clk) begin
    if (tickRst)     divCnt <= '0;
    else if (tickEn) divCnt <= atLimit ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    ctl.clear = letterRst;
    ctl.load  = tick & atTop & ~letterRst;
    ctl.step  = tick & ~atTop & ~letterRst;
  end

  // R1: the tick lasts a single cycle
  p_tick_single_r1: assert property (@(posedge clk) disable iff (tickRst)
    tick |=> !tick);

  // R2: the divider holds while disabled
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (tickRst)
    !tickEn |=> $stable(divCnt));

  // R1: after a tick the divider starts a new period at zero
  p_period_restart_r1: assert property (@(posedge clk) disable iff (tickRst)
    tick |=> divCnt == '0);
endmodule

// File: rtl/alpha_dp.sv
module alpha_dp
  import alpha_pkg::*;
(
  input  logic             clk,
  input  letter_ctl_t      ctl,
  input  logic [IDX_W-1:0] rotIn,
  output logic             atTop,
  output logic [SEG_W-1:0] segOut
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LETTERS - 1);
  localparam logic [IDX_W:0]   WRAP_AT  = (IDX_W+1)'(LETTERS);

  logic [IDX_W-1:0] letterCnt;
  logic [IDX_W-1:0] rotRed;
  logic [IDX_W:0]   rotSum;
  logic [IDX_W-1:0] dispIdx;

  assign atTop = (letterCnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (ctl.clear)     letterCnt <= '0;
    else if (ctl.load) letterCnt <= '0;
    else if (ctl.step) letterCnt <= letterCnt + 1'b1;
  end

  // one subtraction reduces the offset, since 2*LETTERS exceeds 2**IDX_W
  always_comb begin
    rotRed  = ({1'b0, rotIn} >= WRAP_AT) ? IDX_W'({1'b0, rotIn} - WRAP_AT) : rotIn;
    rotSum  = {1'b0, letterCnt} + {1'b0, rotRed};
    dispIdx = (rotSum >= WRAP_AT) ? IDX_W'(rotSum - WRAP_AT) : rotSum[IDX_W-1:0];
  end

  // active-low glyphs, bit 0 = segment a
  always_comb begin
    case (dispIdx)
      5'd0:  segOut = 7'h08;
      5'd1:  segOut = 7'h03;
      5'd2:  segOut = 7'h46;
      5'd3:  segOut = 7'h21;
      5'd4:  segOut = 7'h06;
      5'd5:  segOut = 7'h0E;
      5'd6:  segOut = 7'h42;
      5'd7:  segOut = 7'h09;
      5'd8:  segOut = 7'h4F;
      5'd9:  segOut = 7'h61;
      5'd10: segOut = 7'h0A;
      5'd11: segOut = 7'h47;
      5'd12: segOut = 7'h6A;
      5'd13: segOut = 7'h2B;
      5'd14: segOut = 7'h40;
      5'd15: segOut = 7'h0C;
      5'd16: segOut = 7'h18;
      5'd17: segOut = 7'h2F;
      5'd18: segOut = 7'h12;
      5'd19: segOut = 7'h07;
      5'd20: segOut = 7'h41;
      5'd21: segOut = 7'h63;
      5'd22: segOut = 7'h55;
      5'd23: segOut = 7'h49;
      5'd24: segOut = 7'h11;
      5'd25: segOut = 7'h24;
      default: segOut = 7'h7F;
    endcase
  end

  // R4: the count stays inside the alphabet
  p_range_r4: assert property (@(posedge clk) disable iff (ctl.clear)
    letterCnt <= LAST_IDX);

  // R4: a step adds exactly one
  p_step_r4: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.step |=> letterCnt == $past(letterCnt) + 1'b1);

  // R4: without a strobe the count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (ctl.clear)
    (!ctl.step && !ctl.load) |=> $stable(letterCnt));

  // R5: the reload at the top gives zero
  p_wrap_r5: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.load |=> letterCnt == '0);

  // R7: the rotated index never leaves the table
  p_idx_r7: assert property (@(posedge clk) disable iff (ctl.clear)
    dispIdx <= LAST_IDX);
endmodule

// File: rtl/alpha_stepper.sv
module alpha_stepper
  import alpha_pkg::*;
#(
  parameter int TICK_LIMIT = 7552499
) (
  input  logic       clk,
  input  logic       tickRst,
  input  logic       letterRst,
  input  logic       tickEn,
  input  logic [4:0] rotIn,
  output logic [6:0] segOut,
  output logic       tickDbg
);
  letter_ctl_t ctl;
  logic        atTop;

  alpha_ctrl #(.TICK_LIMIT(TICK_LIMIT)) u_ctrl (
    .clk       (clk),
    .tickRst   (tickRst),
    .tickEn    (tickEn),
    .letterRst (letterRst),
    .atTop     (atTop),
    .ctl       (ctl),
    .tick      (tickDbg)
  );

  alpha_dp u_dp (
    .clk    (clk),
    .ctl    (ctl),
    .rotIn  (rotIn),
    .atTop  (atTop),
    .segOut (segOut)
  );
endmodule

// File: tb/tb_alpha_stepper.sv
`timescale 1ns/1ps
module tb_alpha_stepper;
  localparam int LIM = 9;

  typedef struct {
    string      tag;
    logic [6:0] expSeg;
    logic       expTick;
  } item_t;

  logic       clk = 1'b0;
  logic       tickRst = 1'b1, letterRst = 1'b1, tickEn = 1'b0;
  logic [4:0] rotIn = '0;
  logic [6:0] segOut;
  logic       tickDbg;

  int checks = 0, errors = 0, cycles = 0;
  int mDiv = 0, mCnt = 0;
  bit done = 1'b0;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  alpha_stepper #(.TICK_LIMIT(LIM)) dut (
    .clk(clk), .tickRst(tickRst), .letterRst(letterRst), .tickEn(tickEn),
    .rotIn(rotIn), .segOut(segOut), .tickDbg(tickDbg)
  );

  // R8 glyph table
  function automatic logic [6:0] glyph(input int i);
    case (i)
      0: return 7'h08;  1: return 7'h03;  2: return 7'h46;  3: return 7'h21;
      4: return 7'h06;  5: return 7'h0E;  6: return 7'h42;  7: return 7'h09;
      8: return 7'h4F;  9: return 7'h61; 10: return 7'h0A; 11: return 7'h47;
     12: return 7'h6A; 13: return 7'h2B; 14: return 7'h40; 15: return 7'h0C;
     16: return 7'h18; 17: return 7'h2F; 18: return 7'h12; 19: return 7'h07;
     20: return 7'h41; 21: return 7'h63; 22: return 7'h55; 23: return 7'h49;
     24: return 7'h11; 25: return 7'h24;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic bit modelTick();
    return tickEn && (mDiv == LIM);
  endfunction

  // driver: push the expected outputs for this cycle, then advance the model
  task automatic run(input int n, input string tag, input bit live = 1'b1);
    for (int k = 0; k < n; k++) begin
      item_t it;
      bit t;
      t = modelTick();
      it.tag = tag;
      it.expTick = t;
      it.expSeg = glyph((mCnt + (int'(rotIn) % 26)) % 26);
      if (live) sbq.push_back(it);
      @(posedge clk);
      if (letterRst) mCnt = 0;
      else if (t) mCnt = (mCnt == 25) ? 0 : mCnt + 1;
      if (tickRst) mDiv = 0;
      else if (tickEn) mDiv = (mDiv == LIM) ? 0 : mDiv + 1;
      @(negedge clk);
    end
  endtask

  // monitor: sample one ns before the rising edge
  always @(negedge clk) begin
    #1.5;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (segOut !== it.expSeg || tickDbg !== it.expTick) begin
        errors++;
        $display("FAIL %s: seg=%h tick=%b expected seg=%h tick=%b",
                 it.tag, segOut, tickDbg, it.expSeg, it.expTick);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    run(3, "reset", 1'b0);
    tickRst = 1'b0; letterRst = 1'b0;
    run(1, "R3 R6 reset state");
    tickEn = 1'b1;
    run(LIM + 1, "R3 first tick after divider reset");
    run(30 * (LIM + 1), "R1 R4 R5 R8 full alphabet and wrap");
    tickEn = 1'b0;
    run(25, "R2 disabled divider");
    tickEn = 1'b1;
    run(7, "R2 resume");
    for (int o = 0; o < 32; o++) begin
      rotIn = 5'(o);
      run(1, "R7 offset sweep");
    end
    rotIn = 5'd3;
    while (!(mDiv == LIM - 1)) run(1, "R6 approach");
    run(1, "R6 approach");
    letterRst = 1'b1;
    run(1, "R6 clear against tick");
    letterRst = 1'b0;
    run(3 * (LIM + 1), "R6 R9 after clear, divider phase kept");
    run(4, "R9 mid period");
    tickRst = 1'b1;
    run(1, "R9 divider reset keeps letter");
    tickRst = 1'b0;
    run(3 * (LIM + 1), "R3 R9 restart period");
    rotIn = 5'd30;
    run(28 * (LIM + 1), "R5 R7 wrap under offset");
    letterRst = 1'b1;
    run(1, "R6 clear");
    letterRst = 1'b0; rotIn = 5'd0;
    run(2, "R6 shows A");
    done = 1'b1;
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule